// File: doc/BRIEF.md
# Asynchronous Memory Bus Sequencer

The sequencer takes one read or write request at a time from an internal master. It plays each request out as a timed strobe sequence on an asynchronous parallel memory bus. That bus has four chip-select lines, a read strobe, a write strobe, an address-latch strobe, an address bus and a shared address/data bus. Each access has the following parts, in order:

- An optional multiplexed address stage (address drive, latch pulse, address hold), used only in the multiplexed bus modes.
- A setup stage.
- A strobe stage, during which read data is captured on the last cycle.
- A hold stage.

Every stage length comes from a small programmable cycle count. Reads and writes keep separate setup/strobe/hold counts. The request address picks one of four banks, each with its own enable. Each control line has its own programmable active level.

The master presents a request while `req_ready` is high. It then waits for the single-cycle `done` pulse, which carries the read data. The timing and mode settings are sampled when the request is accepted, so changing them during an access does not disturb that access. Polarity settings are static and act on the pins directly.

The controller state machine has eight states:

| State | Role |
|-------|------|
| IDLE | Waiting for a request |
| ADDR | Address drive |
| LATCH | Latch pulse |
| AHOLD | Address hold after the latch |
| SETUP | Setup stage |
| STROBE | Strobe stage |
| HOLD | Hold stage |
| FINISH | Completion; raises `done` |

The transitions are:

| From | Condition | To |
|------|-----------|----|
| IDLE | Accepted request to a disabled bank | FINISH |
| IDLE | Accepted request, multiplexed mode | ADDR |
| IDLE | Accepted request, setup count non-zero | SETUP |
| IDLE | Accepted request, otherwise | STROBE |
| ADDR | Stage ends | LATCH |
| LATCH | Address-hold count non-zero | AHOLD |
| LATCH | Otherwise | SETUP or STROBE, by the setup count |
| AHOLD | Stage ends | SETUP or STROBE, by the setup count |
| SETUP | Stage ends | STROBE |
| STROBE | Hold count non-zero | HOLD |
| STROBE | Otherwise | FINISH |
| HOLD | Stage ends | FINISH |
| FINISH | Always | IDLE |

Top module: `amem_seq`

## Requirements
- R1: A request is accepted only at a clock edge where `req_valid` is high and `req_ready` is high. `req_ready` is high only in IDLE. A request raised while an access is in progress is ignored and causes no later bus activity.
- R2: The bank index is `req_addr[27:26]` when `cfg_alt_map` is 0, and `req_addr[29:28]` when it is 1. During an enabled access, exactly one chip-select line, `bus_cs[index]`, is active. `bus_addr` carries `req_addr[25:0]` during the strobe.
- R3: A request to a bank whose `cfg_bank_en` bit is 0 raises `done` in the first cycle after acceptance. It activates no bus line and returns `rdata` = 0.
- R4: After any address stage, chip select is active with both strobes inactive for exactly S cycles, where S is the setup count of the access type. S may be 0.
- R5: The read strobe (read) or the write strobe (write) is active for max(T,1) consecutive cycles, where T is the strobe count. The other strobe stays inactive.
- R6: Chip select stays active for exactly H cycles after the strobe, where H is the hold count. `done` rises in the cycle after the last chip-select cycle.
- R7: Reads use `cfg_rd_*` and writes use `cfg_wr_*`. The other set has no effect on the access.
- R8: `rdata` takes `bus_dq_in` from the last strobe cycle of a read. In 8-bit modes (`cfg_mode` 0 or 2), bits 15:8 read as 0. `rdata` holds its value until the next accepted request.
- R9: In multiplexed modes (`cfg_mode` 1 or 2), the access begins as follows. First, `req_addr[15:0]` is driven on `bus_dq_out` with `bus_dq_oe` high and chip select active, for max(D,1) cycles, where D is `cfg_adr_drive`. Next comes one cycle with the latch strobe active. Then come A further cycles, where A is `cfg_adr_hold`. In modes 0 and 3 the latch strobe never becomes active.
- R10: Each polarity bit (`cfg_pol_cs`, `cfg_pol_re`, `cfg_pol_we`, `cfg_pol_ale`) selects active-high when 1 and active-low when 0. Out of reset and whenever IDLE, every control line sits at its inactive level.
- R11: `done` is high for exactly one cycle per accepted request.
- R12: A write drives its data on `bus_dq_out` with `bus_dq_oe` high through the strobe. In 8-bit modes, bits 15:8 of that data are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Bus mode: 0 = 8-bit data, 8-bit address; 1 = 16-bit data, 16-bit address, multiplexed; 2 = 8-bit data, 24-bit address, multiplexed; 3 = 16-bit data, not multiplexed |
| cfg_alt_map | input | 1 | 1 selects 256 MB bank windows instead of 64 MB |
| cfg_bank_en | input | 4 | Per-bank enable |
| cfg_rd_setup | input | 2 | Read setup cycles |
| cfg_rd_strobe | input | 4 | Read strobe cycles (0 acts as 1) |
| cfg_rd_hold | input | 2 | Read hold cycles |
| cfg_wr_setup | input | 2 | Write setup cycles |
| cfg_wr_strobe | input | 4 | Write strobe cycles (0 acts as 1) |
| cfg_wr_hold | input | 2 | Write hold cycles |
| cfg_adr_drive | input | 2 | Address drive cycles before the latch (0 acts as 1) |
| cfg_adr_hold | input | 2 | Address hold cycles after the latch |
| cfg_pol_cs | input | 1 | Chip-select polarity, 1 = active-high |
| cfg_pol_re | input | 1 | Read strobe polarity |
| cfg_pol_we | input | 1 | Write strobe polarity |
| cfg_pol_ale | input | 1 | Latch strobe polarity |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 30 | Request byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `done` |
| bus_cs | output | 4 | Chip-select pins |
| bus_re | output | 1 | Read strobe pin |
| bus_we | output | 1 | Write strobe pin |
| bus_ale | output | 1 | Address-latch strobe pin |
| bus_addr | output | 26 | Address within the bank window |
| bus_dq_out | output | 16 | Shared address/data bus, outgoing value |
| bus_dq_oe | output | 1 | Drive enable for the shared bus |
| bus_dq_in | input | 16 | Shared address/data bus, incoming value |

## Verification
A wrong state or a mis-loaded stage counter appears at the pins within the same access, in one of two ways. One is a strobe, a latch pulse or a chip-select window whose cycle count differs from the programmed count. The other is a `done` pulse that arrives early or late. A bad bank latch shows up in the first active cycle, as the wrong or a second chip-select line. A capture in the wrong cycle returns the bus filler value instead of the data the memory drives during the strobe, and this is visible at the `done` pulse of that read.

// File: rtl/amseq_pkg.sv
`timescale 1ns/1ps
package amseq_pkg;

    localparam int PH_SETUP_W  = 2;
    localparam int PH_STROBE_W = 4;
    localparam int PH_HOLD_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LATCH,
        ST_AHOLD,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [PH_SETUP_W-1:0]  setup;
        logic [PH_STROBE_W-1:0] strobe;
        logic [PH_HOLD_W-1:0]   hold;
    } phase_cfg_t;

    // Bus mode encodings
    localparam logic [1:0] MODE_N8_A8    = 2'd0;
    localparam logic [1:0] MODE_W16_MUX  = 2'd1;
    localparam logic [1:0] MODE_N8_MUX   = 2'd2;
    localparam logic [1:0] MODE_W16_FLAT = 2'd3;

    function automatic logic mode_muxed(input logic [1:0] m);
        return (m == MODE_W16_MUX) || (m == MODE_N8_MUX);
    endfunction

    function automatic logic mode_narrow(input logic [1:0] m);
        return (m == MODE_N8_A8) || (m == MODE_N8_MUX);
    endfunction

endpackage

// File: rtl/amseq_phase_timer.sv
`timescale 1ns/1ps
module amseq_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/amseq_bank_decode.sv
`timescale 1ns/1ps
module amseq_bank_decode #(
    parameter int NBANK      = 4,
    parameter int HI_W       = 4,
    parameter int WIDE_SHIFT = 2
) (
    input  logic [HI_W-1:0]  addr_hi,
    input  logic             alt_map,
    input  logic [NBANK-1:0] bank_en,
    output logic [NBANK-1:0] bank_sel,
    output logic             bank_ok
);
    localparam int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [SEL_W-1:0] idx;

    assign idx = alt_map ? addr_hi[WIDE_SHIFT +: SEL_W] : addr_hi[SEL_W-1:0];

    for (genvar b = 0; b < NBANK; b++) begin : g_sel
        assign bank_sel[b] = (idx == SEL_W'(b));
    end

    assign bank_ok = |(bank_sel & bank_en);
endmodule

// File: rtl/amseq_polarity.sv
`timescale 1ns/1ps
module amseq_polarity #(
    parameter int NCS = 4
) (
    input  logic [NCS-1:0] cs_act,
    input  logic           re_act,
    input  logic           we_act,
    input  logic           ale_act,
    input  logic           pol_cs,
    input  logic           pol_re,
    input  logic           pol_we,
    input  logic           pol_ale,
    output logic [NCS-1:0] cs_pin,
    output logic           re_pin,
    output logic           we_pin,
    output logic           ale_pin
);
    for (genvar c = 0; c < NCS; c++) begin : g_cs
        assign cs_pin[c] = pol_cs ? cs_act[c] : ~cs_act[c];
    end

    assign re_pin  = pol_re  ? re_act  : ~re_act;
    assign we_pin  = pol_we  ? we_act  : ~we_act;
    assign ale_pin = pol_ale ? ale_act : ~ale_act;
endmodule

// File: rtl/amem_seq.sv
`timescale 1ns/1ps
module amem_seq
    import amseq_pkg::*;
#(
    parameter int NBANK      = 4,
    parameter int ADDR_W     = 30,
    parameter int BUS_A_W    = 26,
    parameter int WIDE_LSB   = 28,
    parameter int DATA_W     = 16,
    parameter int NARROW_W   = 8,
    parameter int ADRT_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cfg_mode,
    input  logic                  cfg_alt_map,
    input  logic [NBANK-1:0]      cfg_bank_en,
    input  logic [PH_SETUP_W-1:0] cfg_rd_setup,
    input  logic [PH_STROBE_W-1:0] cfg_rd_strobe,
    input  logic [PH_HOLD_W-1:0]  cfg_rd_hold,
    input  logic [PH_SETUP_W-1:0] cfg_wr_setup,
    input  logic [PH_STROBE_W-1:0] cfg_wr_strobe,
    input  logic [PH_HOLD_W-1:0]  cfg_wr_hold,
    input  logic [ADRT_W-1:0]     cfg_adr_drive,
    input  logic [ADRT_W-1:0]     cfg_adr_hold,
    input  logic                  cfg_pol_cs,
    input  logic                  cfg_pol_re,
    input  logic                  cfg_pol_we,
    input  logic                  cfg_pol_ale,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  req_ready,
    output logic                  done,
    output logic [DATA_W-1:0]     rdata,
    output logic [NBANK-1:0]      bus_cs,
    output logic                  bus_re,
    output logic                  bus_we,
    output logic                  bus_ale,
    output logic [BUS_A_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]     bus_dq_out,
    output logic                  bus_dq_oe,
    input  logic [DATA_W-1:0]     bus_dq_in
);
    localparam int HI_W  = ADDR_W - BUS_A_W;
    localparam int CNT_A = (PH_STROBE_W > PH_SETUP_W) ? PH_STROBE_W : PH_SETUP_W;
    localparam int CNT_B = (PH_HOLD_W > ADRT_W) ? PH_HOLD_W : ADRT_W;
    localparam int CNT_W = (CNT_A > CNT_B) ? CNT_A : CNT_B;
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    seq_state_e         state_q, state_d;

    // Access context captured at acceptance
    logic               wr_q;
    logic [BUS_A_W-1:0] addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [1:0]         mode_q;
    phase_cfg_t         tim_q;
    logic [ADRT_W-1:0]  ad_q, ah_q;
    logic [NBANK-1:0]   bank_q;
    logic [DATA_W-1:0]  rdata_q;

    // Settings in force for next-state decisions
    phase_cfg_t         eff_tim;
    logic               eff_mux;
    logic [ADRT_W-1:0]  eff_ad, eff_ah;
    phase_cfg_t         req_tim;

    logic [NBANK-1:0]   dec_sel;
    logic               dec_ok;
    logic               accept;
    logic               tmr_load, tmr_last;
    logic [CNT_W-1:0]   tmr_val;
    logic               capture;

    logic [NBANK-1:0]   cs_act;
    logic               re_act, we_act, ale_act;

    amseq_bank_decode #(
        .NBANK      (NBANK),
        .HI_W       (HI_W),
        .WIDE_SHIFT (WIDE_LSB - BUS_A_W)
    ) u_dec (
        .addr_hi  (req_addr[ADDR_W-1:BUS_A_W]),
        .alt_map  (cfg_alt_map),
        .bank_en  (cfg_bank_en),
        .bank_sel (dec_sel),
        .bank_ok  (dec_ok)
    );

    amseq_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    amseq_polarity #(.NCS(NBANK)) u_pol (
        .cs_act  (cs_act),
        .re_act  (re_act),
        .we_act  (we_act),
        .ale_act (ale_act),
        .pol_cs  (cfg_pol_cs),
        .pol_re  (cfg_pol_re),
        .pol_we  (cfg_pol_we),
        .pol_ale (cfg_pol_ale),
        .cs_pin  (bus_cs),
        .re_pin  (bus_re),
        .we_pin  (bus_we),
        .ale_pin (bus_ale)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        if (req_write) begin
            req_tim.setup  = cfg_wr_setup;
            req_tim.strobe = cfg_wr_strobe;
            req_tim.hold   = cfg_wr_hold;
        end else begin
            req_tim.setup  = cfg_rd_setup;
            req_tim.strobe = cfg_rd_strobe;
            req_tim.hold   = cfg_rd_hold;
        end
    end

    always_comb begin
        if (state_q == ST_IDLE) begin
            eff_tim = req_tim;
            eff_mux = mode_muxed(cfg_mode);
            eff_ad  = cfg_adr_drive;
            eff_ah  = cfg_adr_hold;
        end else begin
            eff_tim = tim_q;
            eff_mux = mode_muxed(mode_q);
            eff_ad  = ad_q;
            eff_ah  = ah_q;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decisions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!dec_ok)
                        state_d = ST_FINISH;
                    else if (eff_mux)
                        state_d = ST_ADDR;
                    else
                        state_d = (eff_tim.setup != '0) ? ST_SETUP : ST_STROBE;
                end
            end
            ST_ADDR: begin
                if (tmr_last) state_d = ST_LATCH;
            end
            ST_LATCH: begin
                if (tmr_last) begin
                    if (eff_ah != '0)
                        state_d = ST_AHOLD;
                    else
                        state_d = (eff_tim.setup != '0) ? ST_SETUP : ST_STROBE;
                end
            end
            ST_AHOLD: begin
                if (tmr_last)
                    state_d = (eff_tim.setup != '0) ? ST_SETUP : ST_STROBE;
            end
            ST_SETUP: begin
                if (tmr_last) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (tmr_last)
                    state_d = (eff_tim.hold != '0) ? ST_HOLD : ST_FINISH;
            end
            ST_HOLD: begin
                if (tmr_last) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Stage length loaded on every state change (length minus one)
    assign tmr_load = (state_d != state_q);

    always_comb begin
        tmr_val = '0;
        unique case (state_d)
            ST_ADDR:   tmr_val = (eff_ad == '0) ? '0 : CNT_W'(eff_ad) - CNT_W'(1);
            ST_AHOLD:  tmr_val = CNT_W'(eff_ah) - CNT_W'(1);
            ST_SETUP:  tmr_val = CNT_W'(eff_tim.setup) - CNT_W'(1);
            ST_STROBE: tmr_val = (eff_tim.strobe == '0) ? '0
                                 : CNT_W'(eff_tim.strobe) - CNT_W'(1);
            ST_HOLD:   tmr_val = CNT_W'(eff_tim.hold) - CNT_W'(1);
            default:   tmr_val = '0;
        endcase
    end

    assign capture = (state_q == ST_STROBE) && tmr_last && !wr_q;

    // Access context and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            mode_q  <= MODE_N8_A8;
            tim_q   <= '0;
            ad_q    <= '0;
            ah_q    <= '0;
            bank_q  <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr[BUS_A_W-1:0];
            wdata_q <= mode_narrow(cfg_mode) ? (req_wdata & NARROW_MASK) : req_wdata;
            mode_q  <= cfg_mode;
            tim_q   <= req_tim;
            ad_q    <= cfg_adr_drive;
            ah_q    <= cfg_adr_hold;
            bank_q  <= dec_ok ? dec_sel : '0;
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= mode_narrow(mode_q) ? (bus_dq_in & NARROW_MASK) : bus_dq_in;
        end
    end

    // Output decode per state
    always_comb begin
        cs_act     = '0;
        re_act     = 1'b0;
        we_act     = 1'b0;
        ale_act    = 1'b0;
        bus_addr   = '0;
        bus_dq_out = '0;
        bus_dq_oe  = 1'b0;
        req_ready  = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ADDR, ST_AHOLD: begin
                cs_act     = bank_q;
                bus_addr   = addr_q;
                bus_dq_out = addr_q[DATA_W-1:0];
                bus_dq_oe  = 1'b1;
            end
            ST_LATCH: begin
                cs_act     = bank_q;
                ale_act    = 1'b1;
                bus_addr   = addr_q;
                bus_dq_out = addr_q[DATA_W-1:0];
                bus_dq_oe  = 1'b1;
            end
            ST_SETUP, ST_HOLD: begin
                cs_act     = bank_q;
                bus_addr   = addr_q;
                bus_dq_out = wr_q ? wdata_q : '0;
                bus_dq_oe  = wr_q;
            end
            ST_STROBE: begin
                cs_act     = bank_q;
                re_act     = !wr_q;
                we_act     = wr_q;
                bus_addr   = addr_q;
                bus_dq_out = wr_q ? wdata_q : '0;
                bus_dq_oe  = wr_q;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/amseq_checker.sv
`timescale 1ns/1ps
module amseq_checker #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] bus_cs,
    input logic             bus_re,
    input logic             bus_we,
    input logic             bus_ale,
    input logic             pol_cs,
    input logic             pol_re,
    input logic             pol_we,
    input logic             pol_ale,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done,
    input logic [1:0]       mode_q
);
    logic [NBANK-1:0] cs_on;
    logic re_on, we_on, ale_on;

    assign cs_on  = pol_cs  ? bus_cs  : ~bus_cs;
    assign re_on  = pol_re  ? bus_re  : ~bus_re;
    assign we_on  = pol_we  ? bus_we  : ~bus_we;
    assign ale_on = pol_ale ? bus_ale : ~bus_ale;

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_on)); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(re_on && we_on)); // R5

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (re_on || we_on) |-> (cs_on != '0)); // R4

    AST_ALE_MUX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ale_on |-> (mode_q == 2'd1 || mode_q == 2'd2)); // R9

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale_on |=> !ale_on); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_on == '0 && !req_ready)); // R6

    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_on == '0 && !re_on && !we_on && !ale_on)); // R10
endmodule

bind amem_seq amseq_checker #(.NBANK(NBANK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_re    (bus_re),
    .bus_we    (bus_we),
    .bus_ale   (bus_ale),
    .pol_cs    (cfg_pol_cs),
    .pol_re    (cfg_pol_re),
    .pol_we    (cfg_pol_we),
    .pol_ale   (cfg_pol_ale),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .mode_q    (mode_q)
);

// File: tb/sim_amem_seq.sv
`timescale 1ns/1ps
module sim_amem_seq;

    typedef struct packed {
        logic        wr;
        logic [29:0] addr;
        logic [15:0] wdata;
        logic [1:0]  mode;
        logic        alt;
        logic [1:0]  rs;
        logic [3:0]  rt;
        logic [1:0]  rh;
        logic [1:0]  ws;
        logic [3:0]  wt;
        logic [1:0]  wh;
        logic [1:0]  ad;
        logic [1:0]  ah;
        logic [3:0]  pol;   // [3]=cs [2]=re [1]=we [0]=ale
        logic [15:0] rpat;
        logic [2:0]  ebank; // 4 = disabled, no bus activity
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 30'h0400_1234, 16'h0000, 2'd3, 1'b0, 2'd1, 4'd3, 2'd1, 2'd0, 4'd0,  2'd0, 2'd0, 2'd0, 4'b0000, 16'hA5C3, 3'd1},
        '{1'b1, 30'h0000_0ABC, 16'h1357, 2'd1, 1'b0, 2'd3, 4'd9, 2'd3, 2'd2, 4'd0,  2'd1, 2'd0, 2'd2, 4'b1111, 16'h0000, 3'd0},
        '{1'b0, 30'h0C00_00F0, 16'h0000, 2'd0, 1'b0, 2'd0, 4'd0, 2'd0, 2'd3, 4'd15, 2'd3, 2'd1, 2'd1, 4'b0101, 16'hBEEF, 3'd3},
        '{1'b0, 30'h3000_0010, 16'h0000, 2'd2, 1'b1, 2'd2, 4'd15,2'd2, 2'd0, 4'd1,  2'd0, 2'd3, 2'd3, 4'b1010, 16'h7E81, 3'd3},
        '{1'b1, 30'h1C00_0002, 16'hCAFE, 2'd3, 1'b1, 2'd0, 4'd0, 2'd0, 2'd1, 4'd4,  2'd2, 2'd0, 2'd0, 4'b0011, 16'h0000, 3'd1},
        '{1'b0, 30'h1C00_0002, 16'h0000, 2'd1, 1'b0, 2'd0, 4'd1, 2'd0, 2'd3, 4'd3,  2'd3, 2'd1, 2'd0, 4'b0000, 16'h0F0F, 3'd3},
        '{1'b1, 30'h0800_0004, 16'h5555, 2'd1, 1'b0, 2'd1, 4'd1, 2'd1, 2'd1, 4'd1,  2'd1, 2'd1, 2'd1, 4'b1111, 16'h0000, 3'd4},
        '{1'b0, 30'h3800_0000, 16'h0000, 2'd3, 1'b0, 2'd1, 4'd2, 2'd1, 2'd1, 4'd1,  2'd1, 2'd0, 2'd0, 4'b0000, 16'h1234, 3'd4},
        '{1'b1, 30'h0000_5678, 16'hABCD, 2'd2, 1'b0, 2'd1, 4'd1, 2'd1, 2'd0, 4'd2,  2'd0, 2'd2, 2'd1, 4'b1100, 16'h0000, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd3;
    logic        cfg_alt_map = 1'b0;
    logic [3:0]  cfg_bank_en = 4'b1011;
    logic [1:0]  cfg_rd_setup = '0, cfg_wr_setup = '0;
    logic [3:0]  cfg_rd_strobe = '0, cfg_wr_strobe = '0;
    logic [1:0]  cfg_rd_hold = '0, cfg_wr_hold = '0;
    logic [1:0]  cfg_adr_drive = '0, cfg_adr_hold = '0;
    logic        pol_cs = 1'b0, pol_re = 1'b0, pol_we = 1'b0, pol_ale = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [29:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] cur_rpat = '0;

    logic        req_ready, done, bus_re, bus_we, bus_ale, bus_dq_oe;
    logic [15:0] rdata, bus_dq_out, bus_dq_in;
    logic [3:0]  bus_cs;
    logic [25:0] bus_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // Memory model: drives the pattern only while the read strobe is active
    assign bus_dq_in = (bus_re == pol_re) ? cur_rpat : 16'h0BAD;

    amem_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode(cfg_mode), .cfg_alt_map(cfg_alt_map), .cfg_bank_en(cfg_bank_en),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
        .cfg_adr_drive(cfg_adr_drive), .cfg_adr_hold(cfg_adr_hold),
        .cfg_pol_cs(pol_cs), .cfg_pol_re(pol_re), .cfg_pol_we(pol_we), .cfg_pol_ale(pol_ale),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .bus_cs(bus_cs), .bus_re(bus_re), .bus_we(bus_we), .bus_ale(bus_ale),
        .bus_addr(bus_addr), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] cs_on();
        return pol_cs ? bus_cs : ~bus_cs;
    endfunction

    function automatic logic lines_idle();
        return (cs_on() == 4'b0) && (bus_re != pol_re) && (bus_we != pol_we) && (bus_ale != pol_ale);
    endfunction

    task automatic run_vec(input vec_t v, input int n);
        int lat = 0, pre = 0, strb = 0, post = 0, ale_n = 0, other_strb = 0;
        logic seen = 1'b0;
        logic [3:0]  mask = '0;
        logic [15:0] ale_addr = '0, wcap = '0, rcap = '0;
        logic        woe = 1'b0;
        logic [25:0] acap = '0;
        logic        en, mux, nar;
        int s, t, h, te, a;
        en  = (v.ebank != 3'd4);
        mux = (v.mode == 2'd1) || (v.mode == 2'd2);
        nar = (v.mode == 2'd0) || (v.mode == 2'd2);
        s = v.wr ? int'(v.ws) : int'(v.rs);
        t = v.wr ? int'(v.wt) : int'(v.rt);
        h = v.wr ? int'(v.wh) : int'(v.rh);
        te = (t == 0) ? 1 : t;
        a = mux ? ((v.ad == 0) ? 1 : int'(v.ad)) + 1 + int'(v.ah) : 0;

        @(negedge clk);
        cfg_mode = v.mode; cfg_alt_map = v.alt;
        cfg_rd_setup = v.rs; cfg_rd_strobe = v.rt; cfg_rd_hold = v.rh;
        cfg_wr_setup = v.ws; cfg_wr_strobe = v.wt; cfg_wr_hold = v.wh;
        cfg_adr_drive = v.ad; cfg_adr_hold = v.ah;
        {pol_cs, pol_re, pol_we, pol_ale} = v.pol;
        cur_rpat = v.rpat;
        req_write = v.wr; req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 100; k++) begin
            logic re_a, we_a, st_a;
            lat++;
            re_a = (bus_re == pol_re);
            we_a = (bus_we == pol_we);
            st_a = v.wr ? we_a : re_a;
            if ((v.wr ? re_a : we_a)) other_strb++;
            mask |= cs_on();
            if (bus_ale == pol_ale) begin
                ale_n++;
                ale_addr = bus_dq_out;
            end
            if (st_a) begin
                strb++;
                seen = 1'b1;
                acap = bus_addr;
                wcap = bus_dq_out;
                woe  = bus_dq_oe;
            end else if (cs_on() != 4'b0) begin
                if (seen) post++; else pre++;
            end
            if (done) begin
                rcap = rdata;
                break;
            end
            @(negedge clk);
        end

        $display("vector %0d", n);
        chk("R3/R6 latency to done", lat, en ? (a + s + te + h + 1) : 1);
        chk("R2/R3 chip-select mask", mask, en ? (32'd1 << v.ebank) : 0);
        chk("R4/R9 cycles before strobe", pre, en ? (a + s) : 0);
        chk("R5/R7 strobe cycles", strb, en ? te : 0);
        chk("R5 opposite strobe idle", other_strb, 0);
        chk("R6 hold cycles", post, en ? h : 0);
        chk("R9 latch pulses", ale_n, (en && mux) ? 1 : 0);
        if (en && mux) chk("R9 latched address", ale_addr, v.addr[15:0]);
        if (en) chk("R2 bus address", acap, v.addr[25:0]);
        if (!v.wr) chk("R8/R3 read data", rcap, en ? (nar ? {8'h00, v.rpat[7:0]} : v.rpat) : 16'h0);
        if (v.wr && en) begin
            chk("R12 write data", wcap, nar ? {8'h00, v.wdata[7:0]} : v.wdata);
            chk("R12 write drive enable", woe, 1);
        end
        @(negedge clk);
        chk("R10 lines idle after access", lines_idle(), 1);
        chk("R1 ready after access", req_ready, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int flag;
        logic [3:0] mask;
        // Reset state, all lines active-low (R10)
        repeat (3) @(negedge clk);
        chk("R10 reset cs inactive", bus_cs, 4'hF);
        chk("R10 reset re/we/ale inactive", {bus_re, bus_we, bus_ale}, 3'b111);
        chk("R1 ready in reset", req_ready, 1);
        chk("R11 no done in reset", done, 0);
        chk("R8 rdata reset", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Polarity flip while idle moves pins to new inactive level (R10)
        {pol_cs, pol_re, pol_we, pol_ale} = 4'b1111;
        #1;
        chk("R10 active-high idle cs", bus_cs, 4'h0);
        chk("R10 active-high idle strobes", {bus_re, bus_we, bus_ale}, 3'b000);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // Request while busy is ignored (R1); rdata holds (R8)
        @(negedge clk);
        {pol_cs, pol_re, pol_we, pol_ale} = 4'b0000;
        cfg_mode = 2'd3; cfg_alt_map = 1'b0;
        cfg_rd_setup = 2'd0; cfg_rd_strobe = 4'd8; cfg_rd_hold = 2'd0;
        cur_rpat = 16'h4C1D;
        req_write = 1'b0; req_addr = 30'h0000_0010; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        mask = '0;
        for (int k = 1; k < 60; k++) begin
            mask |= cs_on();
            if (k == 2) begin
                chk("R1 ready low while busy", req_ready, 0);
                req_addr = 30'h0400_0000; req_valid = 1'b1;
            end
            if (k == 3) req_valid = 1'b0;
            if (done) break;
            @(negedge clk);
        end
        chk("R1 busy request no second bank", mask, 4'b0001);
        chk("R8 read data", rdata, 16'h4C1D);
        flag = 0;
        cur_rpat = 16'hFFFF;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done || cs_on() != 4'b0) flag++;
        end
        chk("R1/R11 no activity after ignored request", flag, 0);
        chk("R8 rdata held while idle", rdata, 16'h4C1D);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule